// File: doc/BRIEF.md
# Reversible Four-Line Gate Library

A purely combinational set of reversible logic primitives. Every primitive has as many output lines as input lines and keeps all of them, including the lines nobody consumes (garbage). This keeps each gate a one-to-one mapping from input vectors to output vectors.

The central piece is a 4-in/4-out gate (the "quad" gate). With its third input tied low and its fourth input used as carry-in, this single gate gives both the sum and the carry of a one-bit full adder. Around it sit three smaller primitives:
- a 2x2 XOR/copy gate;
- a 3x3 controlled-exchange gate that preserves the number of ones;
- a 3x3 one-through gate.

The top module exposes each primitive and the full-adder wrapper side by side, so each can be used or checked on its own. Nothing is clocked.

Top module: `revlib_top`

## Requirements
- R1: The quad gate maps inputs (a,b,c,d) to p=a, q=(~a&~c)^~b, r=q^d and s=(q&d)^((a&b)^c).
- R2: Each of the four gates is one-to-one: over all of its input vectors (16 for the quad gate, 8 for each 3x3 gate, 4 for the 2x2 gate), no two input vectors give the same output vector.
- R3: The full-adder wrapper drives the quad gate with c=0 and d=cin. Its sum equals bit 0 and its carry equals bit 1 of the arithmetic sum a+b+cin, for all 8 input combinations.
- R4: The full-adder wrapper brings out exactly two garbage lines. junk[1] is the quad gate's p line (equal to a) and junk[0] is its q line (equal to a^b).
- R5: The exchange gate passes x1 to y1. When x1=1, y2=x3 and y3=x2. When x1=0, y2=x2 and y3=x3.
- R6: The exchange gate has the same number of ones on its outputs as on its inputs, for every input vector.
- R7: The one-through gate gives p=a, q=(a&b)^c and r=(~a&~c)^~b.
- R8: The 2x2 gate gives y1=x1 and y2=x1^x2. With x2=0 both outputs equal x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| qg_a | input | 1 | Quad gate line a |
| qg_b | input | 1 | Quad gate line b |
| qg_c | input | 1 | Quad gate line c |
| qg_d | input | 1 | Quad gate line d |
| qg_p | output | 1 | Quad gate output p |
| qg_q | output | 1 | Quad gate output q |
| qg_r | output | 1 | Quad gate output r |
| qg_s | output | 1 | Quad gate output s |
| sw_x1 | input | 1 | Exchange gate control line |
| sw_x2 | input | 1 | Exchange gate data line 2 |
| sw_x3 | input | 1 | Exchange gate data line 3 |
| sw_y1 | output | 1 | Exchange gate control pass-through |
| sw_y2 | output | 1 | Exchange gate output 2 |
| sw_y3 | output | 1 | Exchange gate output 3 |
| ot_a | input | 1 | One-through gate line a |
| ot_b | input | 1 | One-through gate line b |
| ot_c | input | 1 | One-through gate line c |
| ot_p | output | 1 | One-through gate output p |
| ot_q | output | 1 | One-through gate output q |
| ot_r | output | 1 | One-through gate output r |
| xc_x1 | input | 1 | 2x2 gate line 1 |
| xc_x2 | input | 1 | 2x2 gate line 2 |
| xc_y1 | output | 1 | 2x2 gate output 1 |
| xc_y2 | output | 1 | 2x2 gate output 2 |
| fa_a | input | 1 | Full-adder operand a |
| fa_b | input | 1 | Full-adder operand b |
| fa_cin | input | 1 | Full-adder carry in |
| fa_sum | output | 1 | Full-adder sum |
| fa_cout | output | 1 | Full-adder carry out |
| fa_junk | output | 2 | Full-adder garbage lines |

## Verification
The property that is hardest to show from the ports is the one-to-one mapping of each gate. It concerns the whole set of outputs, not any single vector. One bad output can collide with another vector's output while still looking plausible on its own. The stimulus therefore sweeps the full input space of every gate. A record of output vectors already seen flags a collision as soon as a second input lands on an occupied code. The garbage lines of the adder are compared as well, so that the second use of the quad gate is checked on all four of its outputs.

// File: rtl/revlib_pkg.sv
package revlib_pkg;

    localparam int QUAD_LINES  = 4;
    localparam int TRIPLE_LINES = 3;
    localparam int PAIR_LINES  = 2;
    localparam int FA_GARBAGE  = QUAD_LINES - 2;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } quad_vec_t;

    typedef struct packed {
        logic p;
        logic q;
        logic r;
        logic s;
    } quad_out_t;

    function automatic logic [1:0] ones_of3(input logic [2:0] v);
        return 2'(v[0]) + 2'(v[1]) + 2'(v[2]);
    endfunction

endpackage

// File: rtl/rg_quad.sv
module rg_quad
    import revlib_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic d,
    output logic p,
    output logic q,
    output logic r,
    output logic s
);
    quad_vec_t in_v;
    quad_out_t out_v;

    always_comb begin
        in_v    = '{a: a, b: b, c: c, d: d};
        out_v.p = in_v.a;
        out_v.q = (~in_v.a & ~in_v.c) ^ ~in_v.b;
        out_v.r = out_v.q ^ in_v.d;
        out_v.s = (out_v.q & in_v.d) ^ ((in_v.a & in_v.b) ^ in_v.c);
    end

    assign p = out_v.p;
    assign q = out_v.q;
    assign r = out_v.r;
    assign s = out_v.s;

    // R1: line a passes straight through, and d is recoverable from q and r
    always_comb begin
        if (!$isunknown({a, b, c, d})) begin
            p_thru_a_r1: assert (p == a);
            p_d_recover_r1: assert ((q ^ r) == d);
        end
    end
endmodule

// File: rtl/rg_swap.sv
module rg_swap
    import revlib_pkg::*;
(
    input  logic x1,
    input  logic x2,
    input  logic x3,
    output logic y1,
    output logic y2,
    output logic y3
);
    always_comb begin
        y1 = x1;
        y2 = x1 ? x3 : x2;
        y3 = x1 ? x2 : x3;
    end

    // R6: number of ones is conserved
    always_comb begin
        if (!$isunknown({x1, x2, x3})) begin
            p_ones_kept_r6: assert (ones_of3({x1, x2, x3}) == ones_of3({y1, y2, y3}));
        end
    end
endmodule

// File: rtl/rg_onethru.sv
module rg_onethru (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    always_comb begin
        p = a;
        q = (a & b) ^ c;
        r = (~a & ~c) ^ ~b;
    end

    // R7: control line is untouched
    always_comb begin
        if (!$isunknown({a, b, c})) begin
            p_thru_r7: assert (p == a);
        end
    end
endmodule

// File: rtl/rg_xorcopy.sv
module rg_xorcopy (
    input  logic x1,
    input  logic x2,
    output logic y1,
    output logic y2
);
    always_comb begin
        y1 = x1;
        y2 = x1 ^ x2;
    end

    // R8: the second input is recoverable from the two outputs
    always_comb begin
        if (!$isunknown({x1, x2})) begin
            p_undo_r8: assert ((y1 ^ y2) == x2);
        end
    end
endmodule

// File: rtl/rg_fulladd.sv
module rg_fulladd
    import revlib_pkg::*;
(
    input  logic                  a,
    input  logic                  b,
    input  logic                  cin,
    output logic                  sum,
    output logic                  cout,
    output logic [FA_GARBAGE-1:0] junk
);
    logic g_p, g_q;

    rg_quad u_core (
        .a (a),
        .b (b),
        .c (1'b0),
        .d (cin),
        .p (g_p),
        .q (g_q),
        .r (sum),
        .s (cout)
    );

    assign junk = {g_p, g_q};

    // R3: sum and carry match arithmetic addition
    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            p_add_r3: assert ({cout, sum} == (2'(a) + 2'(b) + 2'(cin)));
            p_garbage_r4: assert (junk == {a, a ^ b});
        end
    end
endmodule

// File: rtl/revlib_top.sv
module revlib_top
    import revlib_pkg::*;
(
    input  logic                  qg_a,
    input  logic                  qg_b,
    input  logic                  qg_c,
    input  logic                  qg_d,
    output logic                  qg_p,
    output logic                  qg_q,
    output logic                  qg_r,
    output logic                  qg_s,
    input  logic                  sw_x1,
    input  logic                  sw_x2,
    input  logic                  sw_x3,
    output logic                  sw_y1,
    output logic                  sw_y2,
    output logic                  sw_y3,
    input  logic                  ot_a,
    input  logic                  ot_b,
    input  logic                  ot_c,
    output logic                  ot_p,
    output logic                  ot_q,
    output logic                  ot_r,
    input  logic                  xc_x1,
    input  logic                  xc_x2,
    output logic                  xc_y1,
    output logic                  xc_y2,
    input  logic                  fa_a,
    input  logic                  fa_b,
    input  logic                  fa_cin,
    output logic                  fa_sum,
    output logic                  fa_cout,
    output logic [FA_GARBAGE-1:0] fa_junk
);
    rg_quad u_quad (
        .a(qg_a), .b(qg_b), .c(qg_c), .d(qg_d),
        .p(qg_p), .q(qg_q), .r(qg_r), .s(qg_s)
    );

    rg_swap u_swap (
        .x1(sw_x1), .x2(sw_x2), .x3(sw_x3),
        .y1(sw_y1), .y2(sw_y2), .y3(sw_y3)
    );

    rg_onethru u_onethru (
        .a(ot_a), .b(ot_b), .c(ot_c),
        .p(ot_p), .q(ot_q), .r(ot_r)
    );

    rg_xorcopy u_xorcopy (
        .x1(xc_x1), .x2(xc_x2),
        .y1(xc_y1), .y2(xc_y2)
    );

    rg_fulladd u_fa (
        .a(fa_a), .b(fa_b), .cin(fa_cin),
        .sum(fa_sum), .cout(fa_cout), .junk(fa_junk)
    );
endmodule

// File: tb/revlib_top_test.sv
module revlib_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic qa, qb, qc, qd, qp, qq, qr, qs;
    logic s1, s2, s3, t1, t2, t3;
    logic oa, ob, oc, op, oq, orr;
    logic x1, x2, y1, y2;
    logic fa, fb, fc, fs, fco;
    logic [1:0] fj;

    revlib_top uut (
        .qg_a(qa), .qg_b(qb), .qg_c(qc), .qg_d(qd),
        .qg_p(qp), .qg_q(qq), .qg_r(qr), .qg_s(qs),
        .sw_x1(s1), .sw_x2(s2), .sw_x3(s3),
        .sw_y1(t1), .sw_y2(t2), .sw_y3(t3),
        .ot_a(oa), .ot_b(ob), .ot_c(oc),
        .ot_p(op), .ot_q(oq), .ot_r(orr),
        .xc_x1(x1), .xc_x2(x2), .xc_y1(y1), .xc_y2(y2),
        .fa_a(fa), .fa_b(fb), .fa_cin(fc),
        .fa_sum(fs), .fa_cout(fco), .fa_junk(fj)
    );

    typedef struct packed {
        logic [3:0] idx;
        logic [3:0] e_quad;
        logic [2:0] e_sw;
        logic [2:0] e_ot;
        logic [1:0] e_xc;
        logic [3:0] e_fa;
    } item_t;

    item_t sb[$];
    int n_vec = 0;
    int n_bad = 0;
    bit seen_q[16];
    bit seen_sw[8];
    bit seen_ot[8];
    bit seen_xc[4];
    bit done = 0;

    task automatic cmp(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic uniq(input string req, input bit dup, input logic [3:0] code);
        n_vec++;
        if (dup) begin
            n_bad++;
            $display("FAIL %s actual=repeat of %b expected=unique", req, code);
        end
    endtask

    task automatic drive(input logic [3:0] i);
        item_t it;
        logic q, a, b, c, d;
        logic [1:0] ar;
        @(posedge clk);
        #1;
        {qa, qb, qc, qd} = i;
        {s1, s2, s3} = i[2:0];
        {oa, ob, oc} = i[2:0] ^ 3'b101;
        {x1, x2} = i[1:0];
        {fa, fb, fc} = i[2:0];
        {a, b, c, d} = i;
        q = (~a & ~c) ^ ~b;
        it.idx = i;
        it.e_quad = {a, q, q ^ d, (q & d) ^ ((a & b) ^ c)};
        it.e_sw = i[2] ? {1'b1, i[0], i[1]} : {1'b0, i[1], i[0]};
        it.e_ot = {oa, (oa & ob) ^ oc, (~oa & ~oc) ^ ~ob};
        it.e_xc = {i[1], i[1] ^ i[0]};
        ar = 2'(i[2]) + 2'(i[1]) + 2'(i[0]);
        it.e_fa = {i[2], i[2] ^ i[1], ar[1], ar[0]};
        sb.push_back(it);
    endtask

    // monitor: compare at the falling edge, after inputs settle
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                cmp("R1", {qp, qq, qr, qs}, it.e_quad);
                cmp("R5", {1'b0, t1, t2, t3}, {1'b0, it.e_sw});
                cmp("R6", 4'($countones({t1, t2, t3})), 4'($countones(it.idx[2:0])));
                cmp("R7", {1'b0, op, oq, orr}, {1'b0, it.e_ot});
                cmp("R8", {2'b0, y1, y2}, {2'b0, it.e_xc});
                cmp("R3", {2'b0, fco, fs}, {2'b0, it.e_fa[1:0]});
                cmp("R4", {2'b0, fj}, {2'b0, it.e_fa[3:2]});
                uniq("R2 quad", seen_q[{qp, qq, qr, qs}], {qp, qq, qr, qs});
                seen_q[{qp, qq, qr, qs}] = 1'b1;
                if (it.idx < 8) begin
                    uniq("R2 swap", seen_sw[{t1, t2, t3}], {1'b0, t1, t2, t3});
                    seen_sw[{t1, t2, t3}] = 1'b1;
                    uniq("R2 onethru", seen_ot[{op, oq, orr}], {1'b0, op, oq, orr});
                    seen_ot[{op, oq, orr}] = 1'b1;
                end
                if (it.idx < 4) begin
                    uniq("R2 xorcopy", seen_xc[{y1, y2}], {2'b0, y1, y2});
                    seen_xc[{y1, y2}] = 1'b1;
                end
            end
        end
    end

    initial begin
        {qa, qb, qc, qd, s1, s2, s3, oa, ob, oc, x1, x2, fa, fb, fc} = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        for (int k = 0; k < 16; k++) drive(4'(k));
        repeat (3) @(posedge clk);
        // R8: copy mode with x2 held low
        for (int k = 0; k < 2; k++) begin
            @(posedge clk);
            #1;
            x1 = k[0];
            x2 = 1'b0;
            @(negedge clk);
            cmp("R8 copy", {2'b0, y1, y2}, {2'b0, k[0], k[0]});
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 2000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule